// File: doc/BRIEF.md
# Complementary PWM with dead time

The block produces two complementary pulse outputs, `out_a` and `out_b`, from a single free-running up-counter. The counter's cycle length comes from the `period` input. In half-split mode the first output owns the lower half of the count range and the second output owns the upper half. In variable-split mode the split point comes from the `width` input instead. The `dead` input sets a guard interval that is cut from the start of each output's active phase, so that a pair of power switches driven by the two outputs is never on together.

The settings are captured into holding registers when the block starts and after that only on the last count of a period. A setting changed in the middle of a period therefore takes effect at the next period start and never shortens a pulse already under way. Two single-cycle strobes mark period starts and split points, so a controller can update the settings in step with the waveform. Dropping `run` stops the counter and forces everything inactive.

Top module: `cpwm_deadband`

## Requirements
- R1: While `rst_n` is low or `run` is low, `out_a`, `out_b`, `irq_period` and `irq_phase` are all 0. A clock edge that samples `run` low makes all four 0 after that edge.
- R2: The first edge that samples `run` high puts the counter at 0. The counter then steps by one each cycle up to period-1 and returns to 0. The levels for count k appear on the outputs one cycle after the counter holds k. `irq_period` is a one-cycle pulse for count 0 of every period.
- R3: The `mode` code 2'b10 selects variable-split mode. The codes 2'b00, 2'b01 and 2'b11 all select half-split mode.
- R4: In half-split mode with H = floor(period/2), `out_a` is 1 for counts D <= k < H and `out_b` is 1 for counts H+D <= k < period, where D is the dead time. For an odd period, `out_b` is therefore active for one count more than `out_a`. With D = 0 the two windows cover the whole period with no gap.
- R5: In variable-split mode with 0 < width < period, `out_a` is 1 for counts D <= k < width and `out_b` is 1 for counts width+D <= k < period.
- R6: In variable-split mode with width = 0, `out_a` stays 0 and `out_b` stays 1 for the whole period. With width >= period, `out_a` stays 1 and `out_b` stays 0. In both cases the dead time is not applied and `irq_phase` does not pulse.
- R7: `irq_phase` is a one-cycle pulse for the split count: H in half-split mode, width in variable-split mode.
- R8: `out_a` and `out_b` are never 1 in the same cycle.
- R9: `mode`, `period`, `width` and `dead` are captured when counting starts and on the last count of each period. A change at any other time has no effect until the next period begins.
- R10: A `period` value of 0 or 1 behaves as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = counting, 0 = stopped with outputs inactive |
| mode | input | 2 | 2'b10 = variable split; any other code = half split |
| period | input | CNT_W | Cycle length in clock counts |
| width | input | CNT_W | Split count for variable-split mode |
| dead | input | CNT_W | Guard counts cut from the start of each active phase |
| out_a | output | 1 | First output, active high |
| out_b | output | 1 | Second output, active high |
| irq_period | output | 1 | One-cycle strobe at count 0 |
| irq_phase | output | 1 | One-cycle strobe at the split count |

## Verification
All four outputs are registered. The levels and strobes for the count held by the counter appear one edge later. The edge that samples `run` high loads count 0, so the levels for count 0 appear after the second edge, and a low `run` clears the outputs at the first edge that samples it. A new setting first shows up in the levels for count 0 that follow the wrap edge. The bench's reference model runs at each rising edge from the inputs that edge sees and queues the expected outputs for that edge, and the monitor takes one item from the queue at each following falling edge. Pulse lengths are counted over exactly one period once the waveform has settled, so these counts do not depend on where in the period the window begins.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    MODE_HALF_LO = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_VAR     = 2'b10,
    MODE_HALF_HI = 2'b11
  } cpwm_mode_e;

  localparam int unsigned MIN_PERIOD = 2;

  function automatic logic mode_is_var(logic [1:0] m);
    return m == MODE_VAR;
  endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] dead_o,
  output logic             var_o
);

  localparam logic [CNT_W-1:0] FLOOR_P = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q, wid_q, dt_q;
  logic             run_q, var_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_end, reload;

  function automatic logic [CNT_W-1:0] floor_period(logic [CNT_W-1:0] p);
    return (p < FLOOR_P) ? FLOOR_P : p;
  endfunction

  assign last_cnt = per_q - CNT_W'(1);
  assign at_end   = run_q && (cnt_q == last_cnt);
  assign reload   = !run || !run_q || at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= FLOOR_P;
      wid_q <= '0;
      dt_q  <= '0;
      var_q <= 1'b0;
    end else begin
      run_q <= run;
      if (reload) begin
        cnt_q <= '0;
        per_q <= floor_period(period_i);
        wid_q <= width_i;
        dt_q  <= dead_i;
        var_q <= mode_is_var(mode_i);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign running_o = run_q;
  assign cnt_o     = cnt_q;
  assign period_o  = per_q;
  assign width_o   = wid_q;
  assign dead_o    = dt_q;
  assign var_o     = var_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !at_end) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_end) |=> (cnt_q == '0));

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !at_end) |=>
      ($stable(per_q) && $stable(wid_q) && $stable(dt_q) && $stable(var_q)));

  // R10
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q >= FLOOR_P));

endmodule

// File: rtl/cpwm_shaper.sv
module cpwm_shaper #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] dead,
  input  logic             var_mode,
  output logic             out_a,
  output logic             out_b,
  output logic             irq_period,
  output logic             irq_phase
);

  localparam int unsigned EW = CNT_W + 1;
  typedef logic [EW-1:0] ext_t;

  function automatic logic in_span(ext_t x, ext_t lo, ext_t hi);
    return (x >= lo) && (x < hi);
  endfunction

  function automatic ext_t split_point(logic v, ext_t p, ext_t w);
    return v ? w : (p >> 1);
  endfunction

  ext_t c, p, w, d, split;
  logic clamp_off, clamp_on, live;
  logic a_win, b_win, phase_hit, start_hit;

  assign c     = EW'(cnt);
  assign p     = EW'(period);
  assign w     = EW'(width);
  assign d     = EW'(dead);
  assign split = split_point(var_mode, p, w);

  assign clamp_off = var_mode && (w == '0);
  assign clamp_on  = var_mode && (w >= p);
  assign live      = run && running;

  assign a_win     = clamp_on  | (!clamp_off & in_span(c, d, split));
  assign b_win     = clamp_off | (!clamp_on  & in_span(c, split + d, p));
  assign phase_hit = !clamp_off && !clamp_on && (c == split);
  assign start_hit = (c == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a      <= 1'b0;
      out_b      <= 1'b0;
      irq_period <= 1'b0;
      irq_phase  <= 1'b0;
    end else begin
      out_a      <= live && a_win;
      out_b      <= live && b_win;
      irq_period <= live && start_hit;
      irq_phase  <= live && phase_hit;
    end
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!out_a && !out_b && !irq_period && !irq_phase));

  // R7
  phase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_phase |=> !irq_phase);

  // R2
  period_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |=> !irq_period);

  // R6
  clamp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && clamp_on) |=> (out_a && !out_b && !irq_phase));

  // R6
  clamp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && clamp_off) |=> (!out_a && out_b && !irq_phase));

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] dead,
  output logic             out_a,
  output logic             out_b,
  output logic             irq_period,
  output logic             irq_phase
);

  logic             running;
  logic [CNT_W-1:0] cnt, sh_period, sh_width, sh_dead;
  logic             sh_var;

  cpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode_i    (mode),
    .period_i  (period),
    .width_i   (width),
    .dead_i    (dead),
    .running_o (running),
    .cnt_o     (cnt),
    .period_o  (sh_period),
    .width_o   (sh_width),
    .dead_o    (sh_dead),
    .var_o     (sh_var)
  );

  cpwm_shaper #(.CNT_W(CNT_W)) u_shaper (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .running    (running),
    .cnt        (cnt),
    .period     (sh_period),
    .width      (sh_width),
    .dead       (sh_dead),
    .var_mode   (sh_var),
    .out_a      (out_a),
    .out_b      (out_b),
    .irq_period (irq_period),
    .irq_phase  (irq_phase)
  );

endmodule

// File: tb/cpwm_deadband_test.sv
`timescale 1ns/1ps
module cpwm_deadband_test;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [1:0]    mode = 2'b01;
  logic [CW-1:0] period = 12'd10;
  logic [CW-1:0] width = '0;
  logic [CW-1:0] dead = '0;
  logic          out_a, out_b, irq_period, irq_phase;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  cpwm_deadband #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .period(period),
    .width(width), .dead(dead), .out_a(out_a), .out_b(out_b),
    .irq_period(irq_period), .irq_phase(irq_phase)
  );

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  // Expected {a, b, period strobe, phase strobe} for one count.
  function automatic logic [3:0] predict(bit live, int pos, int per, int wid, int dt, bit v);
    int mark, a_len, b_len;
    bit a, b, ip, ih;
    if (!live) return 4'b0;
    ip = (pos == 0);
    if (v && wid == 0) begin
      a = 0; b = 1; ih = 0;
    end else if (v && wid >= per) begin
      a = 1; b = 0; ih = 0;
    end else begin
      mark  = v ? wid : per / 2;
      a_len = mark - dt;
      b_len = per - mark - dt;
      a  = (pos >= dt) && (pos - dt < a_len);
      b  = (pos >= mark + dt) && (pos - mark - dt < b_len);
      ih = (pos == mark);
    end
    return {a, b, ip, ih};
  endfunction

  // Reference model: one expected item per rising edge.
  logic [3:0] exp_q[$];
  bit m_live = 0;
  int m_pos = 0, m_per = 2, m_wid = 0, m_dt = 0;
  bit m_var = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0; m_pos = 0;
      exp_q.push_back(4'b0);
    end else begin
      exp_q.push_back(predict(run && m_live, m_pos, m_per, m_wid, m_dt, m_var));
      if (!run || !m_live || m_pos == m_per - 1) begin
        m_pos = 0;
        m_per = (int'(period) < 2) ? 2 : int'(period);
        m_wid = int'(width);
        m_dt  = int'(dead);
        m_var = (mode == 2'b10);
      end else begin
        m_pos++;
      end
      m_live = run;
    end
  end

  // Monitor: compare at the falling edge after each rising edge.
  always @(negedge clk) begin
    logic [3:0] e, g;
    if (exp_q.size() > 0 && !finished) begin
      e = exp_q.pop_front();
      g = {out_a, out_b, irq_period, irq_phase};
      chk(e == g, cur_tag, "scoreboard {a,b,ip,ih}", int'(g), int'(e));
      chk(!(out_a && out_b), "R8", "overlap", int'({out_a, out_b}), 0);
    end
  end

  task automatic cfg(logic [1:0] m, int p, int w, int d);
    @(negedge clk);
    mode = m; period = CW'(p); width = CW'(w); dead = CW'(d);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int n, output int na, output int nb, output int ni, output int nh);
    na = 0; nb = 0; ni = 0; nh = 0;
    repeat (n) begin
      @(negedge clk);
      na += int'(out_a); nb += int'(out_b);
      ni += int'(irq_period); nh += int'(irq_phase);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired exp=done");
    finish_run();
  end

  initial begin
    int na, nb, ni, nh;
    // R1: reset state
    cur_tag = "R1";
    cycles(3);
    chk({out_a, out_b, irq_period, irq_phase} == 4'b0, "R1", "reset outputs",
        int'({out_a, out_b, irq_period, irq_phase}), 0);
    rst_n = 1'b1;
    cycles(4);
    chk({out_a, out_b, irq_period, irq_phase} == 4'b0, "R1", "idle outputs",
        int'({out_a, out_b, irq_period, irq_phase}), 0);

    // R4 / R2 / R7: half split, even period, no dead time
    cur_tag = "R4";
    cfg(2'b01, 10, 0, 0);
    run = 1'b1;
    cycles(30);
    measure(10, na, nb, ni, nh);
    chk(na == 5, "R4", "even a len", na, 5);
    chk(nb == 5, "R4", "even b len", nb, 5);
    chk(na + nb == 10, "R4", "no gap at zero dead", na + nb, 10);
    chk(ni == 1, "R2", "period strobes", ni, 1);
    chk(nh == 1, "R7", "phase strobes", nh, 1);

    // R4: odd period with dead time
    @(negedge clk); run = 1'b0;
    cfg(2'b01, 11, 0, 2);
    run = 1'b1;
    cycles(25);
    measure(11, na, nb, ni, nh);
    chk(na == 3, "R4", "odd a len", na, 3);
    chk(nb == 4, "R4", "odd b len", nb, 4);
    chk(nb == na + 1, "R4", "b one longer", nb, na + 1);

    // R5: variable split
    cur_tag = "R5";
    cfg(2'b10, 16, 5, 2);
    cycles(40);
    measure(16, na, nb, ni, nh);
    chk(na == 3, "R5", "var a len", na, 3);
    chk(nb == 9, "R5", "var b len", nb, 9);
    chk(nh == 1, "R7", "var phase strobes", nh, 1);

    // R6: clamps
    cur_tag = "R6";
    cfg(2'b10, 12, 0, 3);
    cycles(40);
    measure(12, na, nb, ni, nh);
    chk(na == 0, "R6", "w0 a len", na, 0);
    chk(nb == 12, "R6", "w0 b len", nb, 12);
    chk(nh == 0, "R6", "w0 phase strobes", nh, 0);
    cfg(2'b10, 12, 12, 3);
    cycles(40);
    measure(12, na, nb, ni, nh);
    chk(na == 12, "R6", "wfull a len", na, 12);
    chk(nb == 0, "R6", "wfull b len", nb, 0);
    chk(nh == 0, "R6", "wfull phase strobes", nh, 0);

    // R3: other mode codes select half split
    cur_tag = "R3";
    cfg(2'b00, 9, 3, 1);
    cycles(30);
    measure(9, na, nb, ni, nh);
    chk(na == 3 && nb == 4, "R3", "code 00 a*16+b", na * 16 + nb, 3 * 16 + 4);
    cfg(2'b11, 9, 3, 1);
    cycles(30);
    measure(9, na, nb, ni, nh);
    chk(na == 3 && nb == 4, "R3", "code 11 a*16+b", na * 16 + nb, 3 * 16 + 4);

    // R9: mid-period change is deferred
    cur_tag = "R9";
    cfg(2'b01, 20, 0, 0);
    cycles(47);
    cfg(2'b01, 8, 0, 1);
    cycles(4);
    cfg(2'b10, 8, 0, 0);
    cycles(3);
    cfg(2'b01, 8, 0, 1);
    cycles(40);

    // R10: tiny periods act as 2
    cur_tag = "R10";
    cfg(2'b01, 1, 0, 0);
    cycles(20);
    measure(10, na, nb, ni, nh);
    chk(ni == 5, "R10", "period 1 strobes", ni, 5);
    chk(na == 5 && nb == 5, "R10", "period 1 a*16+b", na * 16 + nb, 5 * 16 + 5);
    cfg(2'b01, 0, 0, 0);
    cycles(20);
    measure(10, na, nb, ni, nh);
    chk(ni == 5, "R10", "period 0 strobes", ni, 5);

    // R1: stopping mid-period clears the outputs at once
    cur_tag = "R1";
    cfg(2'b10, 30, 20, 0);
    cycles(45);
    chk(out_a == 1'b1, "R1", "a active before stop", int'(out_a), 1);
    run = 1'b0;
    @(negedge clk);
    chk({out_a, out_b, irq_period, irq_phase} == 4'b0, "R1", "outputs after stop",
        int'({out_a, out_b, irq_period, irq_phase}), 0);
    measure(6, na, nb, ni, nh);
    chk(na + nb + ni + nh == 0, "R1", "stopped activity", na + nb + ni + nh, 0);

    // R2: restart begins at count 0
    cur_tag = "R2";
    cfg(2'b01, 6, 0, 0);
    run = 1'b1;
    @(negedge clk);
    chk(irq_period == 1'b0, "R2", "no strobe on start edge", int'(irq_period), 0);
    @(negedge clk);
    chk(irq_period == 1'b1 && out_a == 1'b1, "R2", "count 0 after second edge",
        int'({irq_period, out_a}), 3);
    cycles(20);

    finish_run();
  end

endmodule